// File: doc/BRIEF.md
# Nested-Loop Micro-Sequencer

This block walks a built-in program of microinstruction words, one word per clock, and drives the control field of the current word onto an output vector. External datapath blocks act on that vector. The sequencer computes nothing itself. Its program flow includes counted loops whose repeat count and closing address are fixed inside the loop instruction. A small hardware stack keeps one context for each open loop or subroutine call, so loops can be nested several levels deep without any software counter. It also supports an unconditional jump, a jump taken on one of the external condition inputs, a subroutine call and return, and a halt.

A system pulses `start_i`. The sequencer then runs from address 0 until it executes a halt word. After that it raises `done_o` and waits for the next start. Each instruction word has these fields: an opcode, a condition select, a repeat count, a target address (the jump or call destination, or the loop's closing address) and the control bits. The loop-closing check is made on every running cycle. When the current address equals the closing address of the innermost open loop, that check decides the next address, and it overrides the flow of the word there (a halt still halts). A program must therefore not close two loops at the same address.

The built-in program exercises every feature, using the default widths (5-bit address, 8-bit control). The control field of every word is 8'hA0 OR its address. The program is laid out as follows:
- Address 0 opens a loop with count 2, closing at 4.
- Address 1 opens a loop with count 1, closing at 3.
- Address 5 calls a subroutine at 24–25; the word at 25 is a return.
- Address 6 jumps to 9 when condition bit 0 is 1. Otherwise it falls through to 7, and address 8 jumps to 10.
- Address 10 jumps to 12 when condition bit 1 is 1. Otherwise it falls through to a halt at 11.
- Addresses 12–15 open four loops with count 0, closing at 20, 19, 18 and 17.
- Address 16 tries a fifth push: a loop with count 3, closing at 17.
- Address 21 halts.
- Every address not listed above is a halt.

Top module: `loopseq_top`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `ctrl_o` are all 0, and the sequencer stays idle for as long as `start_i` is low.
- R2: A start seen while the sequencer is idle or done makes the cycle after that edge execute address 0. One word executes per clock. While running, `ctrl_o` equals the control field of the word executing, which is 8'hA0 OR its address; when not running, `ctrl_o` is 0.
- R3: A loop word with count n and closing address E pushes a context and falls through. Each time E executes while that context's count is nonzero, the next address is the word after the loop word and the count drops by one. The body therefore runs n+1 times.
- R4: When E executes with a count of zero, the context is popped and execution falls through to E+1. An inner loop runs in full on each pass of an outer loop, so the program's nested section yields the address trace 0,(1,2,3,2,3,4)×3,5.
- R5: A call pushes the address after the call and jumps to its target. A return pops that address and resumes there.
- R6: A plain jump always goes to its target. A conditional jump goes to its target when `cond_i[sel]` is 1, and falls through otherwise.
- R7: The stack holds 4 contexts. A push onto a full stack is ignored, execution falls through, and `err_o` is set. `err_o` then stays 1 until reset, whatever later runs do.
- R8: A halt word drives its own control field for one cycle. After it `busy_o` is 0, `ctrl_o` is 0 and `done_o` is 1, and these stay until the next start. A start while running has no effect on the trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a program run from address 0 when idle or done |
| cond_i | input | COND_W | External condition bits tested by conditional jumps |
| ctrl_o | output | CTRL_W | Control field of the executing word, 0 when not running |
| busy_o | output | 1 | Program is running |
| done_o | output | 1 | Halt reached; held until the next start |
| err_o | output | 1 | Sticky stack-overflow flag |

## Verification
The hardest situation to reach is a push onto a full stack. Only the path with condition bit 1 set reaches the deep nest of four open loops, followed by a fifth loop word whose count would trap execution if the push were wrongly accepted. Random runs draw the condition bits, the idle gaps and stray start pulses during a run. A directed first run with both bits clear shows that the error flag stays low, and a directed second run with both bits set drives the overflow. The bench checks that the flag then persists through later runs that do not overflow, and that reset clears it.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_JMP  = 3'd1,
        OP_JMPC = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_LOOP = 3'd5,
        OP_HALT = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_st_e;

endpackage

// File: rtl/loopseq_rom.sv
module loopseq_rom
    import loopseq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CTRL_W = 8,
    parameter int CNT_W  = 4,
    parameter int SEL_W  = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] tgt_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    typedef struct packed {
        op_e               op;
        logic [SEL_W-1:0]  sel;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] tgt;
    } word_t;

    function automatic word_t mk(op_e op, int sel, int cnt, int tgt);
        word_t w;
        w.op  = op;
        w.sel = SEL_W'(sel);
        w.cnt = CNT_W'(cnt);
        w.tgt = ADDR_W'(tgt);
        return w;
    endfunction

    // Program listing; unlisted addresses halt.
    function automatic word_t prog(int a);
        case (a)
            0:       return mk(OP_LOOP, 0, 2, 4);
            1:       return mk(OP_LOOP, 0, 1, 3);
            5:       return mk(OP_CALL, 0, 0, 24);
            6:       return mk(OP_JMPC, 0, 0, 9);
            8:       return mk(OP_JMP,  0, 0, 10);
            10:      return mk(OP_JMPC, 1, 0, 12);
            12:      return mk(OP_LOOP, 0, 0, 20);
            13:      return mk(OP_LOOP, 0, 0, 19);
            14:      return mk(OP_LOOP, 0, 0, 18);
            15:      return mk(OP_LOOP, 0, 0, 17);
            16:      return mk(OP_LOOP, 0, 3, 17);
            2, 3, 4, 7, 9, 17, 18, 19, 20, 24:
                     return mk(OP_NOP,  0, 0, 0);
            25:      return mk(OP_RET,  0, 0, 0);
            default: return mk(OP_HALT, 0, 0, 0);
        endcase
    endfunction

    word_t word;

    always_comb begin
        word   = prog(int'(addr_i));
        op_o   = word.op;
        sel_o  = word.sel;
        cnt_o  = word.cnt;
        tgt_o  = word.tgt;
        ctrl_o = CTRL_W'(32'hA0 | 32'(addr_i));
    end

endmodule

// File: rtl/loopseq_stack.sv
module loopseq_stack #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 4,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic              push_loop_i,
    input  logic [ADDR_W-1:0] push_start_i,
    input  logic [ADDR_W-1:0] push_end_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    input  logic              pop_i,
    input  logic              dec_i,
    output logic              top_valid_o,
    output logic              top_loop_o,
    output logic [ADDR_W-1:0] top_start_o,
    output logic [ADDR_W-1:0] top_end_o,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic              full_o,
    output logic [SP_W-1:0]   sp_o
);

    typedef struct packed {
        logic              loop;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] fin;
        logic [CNT_W-1:0]  cnt;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [SP_W-1:0]    sp;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             empty;

    assign empty   = (stk_q.sp == '0);
    assign full_o  = (stk_q.sp == SP_W'(DEPTH));
    assign top_idx = IDX_W'(stk_q.sp - SP_W'(1));
    assign wr_idx  = IDX_W'(stk_q.sp);

    always_comb begin
        stk_d = stk_q;
        if (clr_i) begin
            stk_d.sp = '0;
        end else if (push_i && !full_o) begin
            stk_d.ent[wr_idx].loop  = push_loop_i;
            stk_d.ent[wr_idx].start = push_start_i;
            stk_d.ent[wr_idx].fin   = push_end_i;
            stk_d.ent[wr_idx].cnt   = push_cnt_i;
            stk_d.sp                = stk_q.sp + SP_W'(1);
        end else if (pop_i && !empty) begin
            stk_d.sp = stk_q.sp - SP_W'(1);
        end else if (dec_i && !empty) begin
            stk_d.ent[top_idx].cnt = stk_q.ent[top_idx].cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign top_valid_o = !empty;
    assign top_loop_o  = stk_q.ent[top_idx].loop;
    assign top_start_o = stk_q.ent[top_idx].start;
    assign top_end_o   = stk_q.ent[top_idx].fin;
    assign top_cnt_o   = stk_q.ent[top_idx].cnt;
    assign sp_o        = stk_q.sp;

endmodule

// File: rtl/loopseq_top.sv
module loopseq_top
    import loopseq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CTRL_W = 8,
    parameter int CNT_W  = 4,
    parameter int COND_W = 2,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COND_W-1:0] cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int SEL_W = (COND_W > 1) ? $clog2(COND_W) : 1;
    localparam int SP_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] pc;
        logic              err;
    } core_t;

    core_t core_d, core_q;

    op_e               w_op;
    logic [SEL_W-1:0]  w_sel;
    logic [CNT_W-1:0]  w_cnt;
    logic [ADDR_W-1:0] w_tgt;
    logic [CTRL_W-1:0] w_ctrl;

    logic              s_clr, s_push, s_push_loop, s_pop, s_dec;
    logic [ADDR_W-1:0] s_push_start, s_push_end;
    logic [CNT_W-1:0]  s_push_cnt;
    logic              t_valid, t_loop, s_full;
    logic [ADDR_W-1:0] t_start, t_end;
    logic [CNT_W-1:0]  t_cnt;
    logic [SP_W-1:0]   stk_sp;

    logic [ADDR_W-1:0] pc_inc;
    logic              at_end;
    logic              running;

    loopseq_rom #(
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) rom_i (
        .addr_i(core_q.pc), .op_o(w_op), .sel_o(w_sel), .cnt_o(w_cnt),
        .tgt_o(w_tgt), .ctrl_o(w_ctrl)
    );

    loopseq_stack #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
    ) stk_i (
        .clk(clk), .rst_n(rst_n), .clr_i(s_clr),
        .push_i(s_push), .push_loop_i(s_push_loop),
        .push_start_i(s_push_start), .push_end_i(s_push_end),
        .push_cnt_i(s_push_cnt), .pop_i(s_pop), .dec_i(s_dec),
        .top_valid_o(t_valid), .top_loop_o(t_loop),
        .top_start_o(t_start), .top_end_o(t_end), .top_cnt_o(t_cnt),
        .full_o(s_full), .sp_o(stk_sp)
    );

    assign running = (core_q.st == SQ_RUN);
    assign pc_inc  = core_q.pc + ADDR_W'(1);
    assign at_end  = t_valid && t_loop && (core_q.pc == t_end);

    always_comb begin
        core_d       = core_q;
        s_clr        = 1'b0;
        s_push       = 1'b0;
        s_push_loop  = 1'b0;
        s_push_start = pc_inc;
        s_push_end   = w_tgt;
        s_push_cnt   = w_cnt;
        s_pop        = 1'b0;
        s_dec        = 1'b0;
        case (core_q.st)
            SQ_RUN: begin
                if (w_op == OP_HALT) begin
                    core_d.st = SQ_DONE;
                end else if (at_end) begin
                    // closing address of innermost loop decides the flow
                    if (t_cnt != '0) begin
                        core_d.pc = t_start;
                        s_dec     = 1'b1;
                    end else begin
                        core_d.pc = pc_inc;
                        s_pop     = 1'b1;
                    end
                end else begin
                    core_d.pc = pc_inc;
                    case (w_op)
                        OP_JMP:  core_d.pc = w_tgt;
                        OP_JMPC: if (cond_i[w_sel]) core_d.pc = w_tgt;
                        OP_CALL: begin
                            if (s_full) begin
                                core_d.err = 1'b1;
                            end else begin
                                s_push    = 1'b1;
                                core_d.pc = w_tgt;
                            end
                        end
                        OP_RET: begin
                            if (t_valid && !t_loop) begin
                                core_d.pc = t_start;
                                s_pop     = 1'b1;
                            end
                        end
                        OP_LOOP: begin
                            if (s_full) core_d.err = 1'b1;
                            else begin
                                s_push      = 1'b1;
                                s_push_loop = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: begin
                if (start_i) begin
                    core_d.st = SQ_RUN;
                    core_d.pc = '0;
                    s_clr     = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{st: SQ_IDLE, pc: '0, err: 1'b0};
        else        core_q <= core_d;
    end

    assign ctrl_o = running ? w_ctrl : '0;
    assign busy_o = running;
    assign done_o = (core_q.st == SQ_DONE);
    assign err_o  = core_q.err;

endmodule

// File: rtl/loopseq_chk.sv
module loopseq_chk #(
    parameter int SP_W  = 3,
    parameter int DEPTH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [SP_W-1:0] sp
);

    // R1
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH));

endmodule

bind loopseq_top loopseq_chk #(.SP_W(SP_W), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .sp(stk_sp)
);

// File: tb/loopseq_tb.sv
module loopseq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] cond_i = 2'b00;
    logic [7:0] ctrl_o;
    logic       busy_o, done_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit exp_err = 0;

    always #5 clk = ~clk;

    loopseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_i(cond_i),
        .ctrl_o(ctrl_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected address trace from the program listing
    function automatic void build(input logic [1:0] c, ref int q[$]);
        q.delete();
        q.push_back(0);
        for (int o = 0; o < 3; o++) begin            // R3 outer count 2
            q.push_back(1);
            for (int i = 0; i < 2; i++) begin        // R4 inner count 1
                q.push_back(2); q.push_back(3);
            end
            q.push_back(4);
        end
        q.push_back(5); q.push_back(24); q.push_back(25); q.push_back(6); // R5
        if (c[0]) q.push_back(9);                    // R6
        else begin q.push_back(7); q.push_back(8); end
        q.push_back(10);
        if (c[1]) for (int a = 12; a <= 21; a++) q.push_back(a); // R7
        else q.push_back(11);
    endfunction

    task automatic run(input logic [1:0] c, input int gap, input bit noise);
        int q[$];
        build(c, q);
        cond_i = c;
        repeat (gap) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            chk("R2 busy", int'(busy_o), 1);
            chk("R2/R3/R4/R5/R6 ctrl", int'(ctrl_o), 'hA0 | q[i]);
            start_i = noise ? (($urandom % 6) == 0) : 1'b0;  // R8 ignored
            @(negedge clk);
        end
        start_i = 1'b0;
        if (c[1]) exp_err = 1;
        chk("R8 done", int'(done_o), 1);
        chk("R8 idle busy", int'(busy_o), 0);
        chk("R8 ctrl zero", int'(ctrl_o), 0);
        chk("R7 err", int'(err_o), int'(exp_err));
        @(negedge clk);
        chk("R8 done held", int'(done_o), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 ctrl", int'(ctrl_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 stays idle", int'(busy_o), 0);
        chk("R1 no done", int'(done_o), 0);
        run(2'b00, 0, 0);
        run(2'b11, 1, 0);
        run(2'b01, 0, 1);
        run(2'b10, 2, 1);
        for (int k = 0; k < 40; k++)
            run(2'($urandom % 4), int'($urandom % 5), 1);
        // R7 reset clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 err cleared by reset", int'(err_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        exp_err = 0;
        run(2'b01, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=halted");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule